// File: doc/BRIEF.md
# Strand Pause Counter Unit

This unit holds one hardware thread in a stalled state for a number of clock cycles chosen by software. A single write delivers a requested cycle amount; the unit drops the three least significant bits and loads the remainder into a coarse down-counter. The counter steps once every eight clock cycles, so the stall lasts the requested amount rounded down to a multiple of eight. A request too small to give even one step still stalls the thread for a single cycle.

While the stall is in force, a disrupting trap ends it at once, whatever the remaining count. A new write during a stall replaces the remaining count and restarts the eight-cycle phase. Whenever a stall ends, whether it ran out or was cut short, a one-cycle completion pulse follows. Both outputs come straight from registers.

Top module: `strand_pause_unit`

## Requirements
- R1: After synchronous reset both `stall_o` and `done_o` are low.
- R2: A write of value V with V >= 8 raises `stall_o` from the first cycle after the write edge, and it stays high for exactly 8*(V>>3) cycles.
- R3: Bits [2:0] of the written value have no effect on the stall length (a write of 23 stalls for 16 cycles).
- R4: A write of a value below 8 (including 0) stalls for exactly 1 cycle.
- R5: `trap_in` high during a stall with no write in that cycle makes `stall_o` low in the next cycle, with `done_o` high in that cycle.
- R6: When a stall ends, `done_o` is high for exactly one cycle, the first cycle in which `stall_o` is low.
- R7: A write during a stall reloads the count and restarts the eight-cycle phase: the stall then lasts 8*(V>>3) cycles from the new write, and no `done_o` pulse is produced at the reload.
- R8: `trap_in` while no stall is in force has no effect: `stall_o` and `done_o` stay low.
- R9: When a write and `trap_in` occur in the same cycle, the write wins and the stall runs its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_wr | input | 1 | Write strobe for a pause request |
| pause_val | input | DATA_W (64) | Requested pause length in cycles |
| trap_in | input | 1 | Disrupting trap, ends a stall early |
| stall_o | output | 1 | Thread is held while high |
| done_o | output | 1 | One-cycle pulse after a stall ends |

## Verification
The checker watches on every cycle that a write always leads to a stall with no completion pulse, that the completion pulse is single and only follows a stall that has just dropped, that a trap ends a stall within one cycle, that an idle unit stays idle without a write, and that the count never rises while a stall runs. The exact stall lengths for different written values, the discarding of the low three bits, the minimum one-cycle stall and the length after a mid-stall reload can only be shown by the bench's scenarios, which count stalled cycles against the values computed from the written amounts.

// File: rtl/strand_pause_pkg.sv
package strand_pause_pkg;
  parameter int unsigned DEF_DATA_W = 64;
  parameter int unsigned DEF_SHIFT  = 3;

  // number of clock cycles covered by one counter step
  function automatic int unsigned step_cycles(input int unsigned shift);
    return 32'd1 << shift;
  endfunction
endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int unsigned SHIFT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam logic [SHIFT-1:0] LAST_PHASE = '1;

  logic [SHIFT-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && !restart && (phase_q == LAST_PHASE);
endmodule

// File: rtl/pause_counter.sv
module pause_counter #(
  parameter int unsigned CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             abort,
  output logic [CNT_W-1:0] count,
  output logic             is_zero,
  output logic             is_one
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (abort) begin
      count_q <= '0;
    end else if (step && (count_q != '0)) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign count   = count_q;
  assign is_zero = (count_q == '0);
  assign is_one  = (count_q == CNT_W'(1));
endmodule

// File: rtl/strand_pause_unit.sv
module strand_pause_unit #(
  parameter int unsigned DATA_W = strand_pause_pkg::DEF_DATA_W,
  parameter int unsigned SHIFT  = strand_pause_pkg::DEF_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pause_wr,
  input  logic [DATA_W-1:0] pause_val,
  input  logic              trap_in,
  output logic              stall_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = DATA_W - SHIFT;

  logic             stall_q;
  logic             done_q;
  logic             tick;
  logic             cnt_zero;
  logic             cnt_one;
  logic             finish;
  logic [CNT_W-1:0] cnt_val;

  // a stall ends on a trap, on the minimum one-cycle case, or on the last step
  assign finish = stall_q && !pause_wr &&
                  (trap_in || cnt_zero || (cnt_one && tick));

  pause_prescaler #(.SHIFT(SHIFT)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (pause_wr),
    .run     (stall_q),
    .tick    (tick)
  );

  pause_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (pause_wr),
    .load_val (pause_val[DATA_W-1:SHIFT]),
    .step     (tick),
    .abort    (finish),
    .count    (cnt_val),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (pause_wr) begin
        stall_q <= 1'b1;
      end else if (finish) begin
        stall_q <= 1'b0;
      end
    end
  end

  assign stall_o = stall_q;
  assign done_o  = done_q;
endmodule

// File: rtl/strand_pause_chk.sv
module strand_pause_chk #(
  parameter int unsigned CNT_W = 61
) (
  input logic             clk,
  input logic             rst,
  input logic             pause_wr,
  input logic             trap_in,
  input logic             stall_o,
  input logic             done_o,
  input logic [CNT_W-1:0] cnt_val
);
  // R2
  wr_starts_stall_chk: assert property (@(posedge clk) disable iff (rst)
    pause_wr |=> (stall_o && !done_o));

  // R5
  trap_ends_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_o && trap_in && !pause_wr) |=> (!stall_o && done_o));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  done_after_stall_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!stall_o && $past(stall_o)));

  // R8
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall_o && !pause_wr) |=> (!stall_o && !done_o));

  // R7
  count_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_o && !pause_wr) |=> (cnt_val <= $past(cnt_val)));
endmodule

bind strand_pause_unit strand_pause_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pause_wr (pause_wr),
  .trap_in  (trap_in),
  .stall_o  (stall_o),
  .done_o   (done_o),
  .cnt_val  (cnt_val)
);

// File: tb/test_strand_pause_unit.sv
module test_strand_pause_unit;
  localparam int unsigned DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              pause_wr;
  logic [DATA_W-1:0] pause_val;
  logic              trap_in;
  logic              stall_o;
  logic              done_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  strand_pause_unit #(.DATA_W(DATA_W), .SHIFT(3)) i_strand_pause_unit (
    .clk       (clk),
    .rst       (rst),
    .pause_wr  (pause_wr),
    .pause_val (pause_val),
    .trap_in   (trap_in),
    .stall_o   (stall_o),
    .done_o    (done_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write at the next edge; returns at the negedge after it
  task automatic do_write(input longint val, input logic with_trap);
    pause_val = DATA_W'(val);
    pause_wr  = 1'b1;
    trap_in   = with_trap;
    @(negedge clk);
    pause_wr  = 1'b0;
    trap_in   = 1'b0;
  endtask

  // count stalled cycles from the current negedge, then check the done pulse
  task automatic measure(input string req, input int exp_len);
    int len = 0;
    while (stall_o && len < 5000) begin
      len++;
      @(negedge clk);
    end
    check(req, len, exp_len);
    check({req, " done"}, done_o, 1);
    @(negedge clk);
    check({req, " done width"}, done_o, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; pause_wr = 1'b0; pause_val = '0; trap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stall", stall_o, 0);
    check("R1 done", done_o, 0);
  endtask

  task automatic t_length(input string req, input longint val, input int exp_len);
    do_write(val, 1'b0);
    check({req, " no done at start"}, done_o, 0);
    measure(req, exp_len);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_trap;
    do_write(800, 1'b0);
    repeat (5) @(negedge clk);
    check("R5 still stalled", stall_o, 1);
    trap_in = 1'b1;
    @(negedge clk);
    trap_in = 1'b0;
    check("R5 stall cut", stall_o, 0);
    check("R5 done", done_o, 1);
    @(negedge clk);
    check("R6 done after trap width", done_o, 0);
  endtask

  task automatic t_reload;
    do_write(80, 1'b0);
    repeat (21) @(negedge clk);
    do_write(16, 1'b0);
    check("R7 no done at reload", done_o, 0);
    check("R7 stall kept", stall_o, 1);
    measure("R7 reload length", 16);
  endtask

  task automatic t_idle_trap;
    trap_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 idle trap stall", stall_o, 0);
      check("R8 idle trap done", done_o, 0);
    end
    trap_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_wr_trap;
    do_write(24, 1'b1);
    measure("R9 write beats trap", 24);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_length("R2 len 64", 64, 64);
    t_length("R2 len 8", 8, 8);
    t_length("R2 len 200", 200, 200);
    t_length("R3 low bits dropped", 23, 16);
    t_length("R4 zero write", 0, 1);
    t_length("R4 write 7", 7, 1);
    t_trap();
    t_reload();
    t_idle_trap();
    t_wr_trap();
    t_length("R6 done after expiry", 40, 40);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule